// File: doc/BRIEF.md
# Lowest-Priority Destination Arbiter

This block chooses exactly one target out of a group of processor interrupt units when an interrupt is to be delivered to whichever of them is currently least busy. Each unit offers an 8-bit processor priority, a bit in a destination bitmask and a flag that says whether its processor has been started. A unit can win only when it is in the destination set and has started. Units are compared on the high nibble of their priority alone, and the lowest high nibble wins.

A single-cycle request strobe samples all inputs. The block then visits one candidate per clock. Visiting starts at a rotating pointer and wraps modulo N. A candidate displaces the current best only when its key is strictly lower. Because of this, the first unit visited wins any tie, and moving the pointer to one past each winner spreads ties across the units over time. When the walk ends, a one-cycle done strobe presents a found flag, a winner index and a one-hot winner mask.

Top module: `lowpri_arbiter`

## Requirements
- R1: A unit is eligible only when its destination bit and its started bit are both 1. A unit failing either test is never chosen, even when it has the lowest priority.
- R2: Priority byte p of unit u sits in prio_i[8u+7:8u], and only p[7:4] takes part in the comparison. Two units whose priorities differ only in bits 3:0 are treated as equal.
- R3: Among the eligible units, the one with the smallest p[7:4] is chosen.
- R4: Candidates are visited in the order (ptr + i) mod N for i = 0..N-1. A later candidate replaces the best only when its key is strictly smaller, so on a tie the first one visited wins.
- R5: The rotation pointer is 0 after reset. After an arbitration that finds a winner, it becomes (winner index + 1) mod N.
- R6: With the result, found_o is 1, win_idx_o holds the winner's index and win_mask_o has only bit win_idx_o set. All three hold their values until the next done. After reset all three are 0.
- R7: When no unit is eligible, found_o is 0, win_mask_o is 0 and the rotation pointer keeps its value.
- R8: If req_i is sampled high at clock edge k while the block is idle, done_o is 1 for exactly the one cycle that follows edge k+N. done_o is 0 after reset.
- R9: Inputs are sampled only at the accepting edge. A req_i pulse, or any input change, while a walk is in progress has no effect on the result or on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start strobe; samples all other inputs when the block is idle |
| dest_i | input | N | Destination bitmask, one bit per unit |
| started_i | input | N | Processor-started flag, one bit per unit |
| prio_i | input | 8*N | Processor priorities, byte u belongs to unit u |
| done_o | output | 1 | One-cycle strobe: result valid |
| found_o | output | 1 | An eligible unit was chosen |
| win_mask_o | output | N | One-hot mask of the chosen unit, zero if none |
| win_idx_o | output | $clog2(N) | Index of the chosen unit |

## Verification
Every result arrives a fixed N clock edges after the edge that accepts the request. No other stimulus moves it earlier or later. When the driver issues a request, it notes the cycle counter, works out the expected winner from its own ring walk, and queues the item together with the cycle at which the item is due. The monitor samples on the falling edge. Each time it sees done, it pops the oldest item and compares the found flag, index and mask, and it also compares the current cycle with the due cycle, so a result that comes early, comes late, or comes with nothing queued is reported.

// File: rtl/lp_arb_pkg.sv
package lp_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int NIB_W  = 4;
  localparam int KEY_W  = NIB_W + 1;
  // Key above every real priority nibble; any eligible unit beats it.
  localparam logic [KEY_W-1:0] KEY_NONE = KEY_W'(1) << NIB_W;

  // Comparison key: upper nibble only, widened by one bit.
  function automatic logic [KEY_W-1:0] prio_key(input logic [PRIO_W-1:0] p);
    return {1'b0, p[PRIO_W-1 -: NIB_W]};
  endfunction

  // Modular addition on a ring of n slots, both operands below n.
  function automatic logic [31:0] ring_add(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input logic [31:0] n);
    logic [31:0] s;
    s = a + b;
    return (s >= n) ? (s - n) : s;
  endfunction
endpackage

// File: rtl/lp_eligible.sv
module lp_eligible
  import lp_arb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]        dest,
  input  logic [N-1:0]        started,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic [N-1:0]        elig,
  output logic [N*KEY_W-1:0]  key_flat
);
  for (genvar g = 0; g < N; g++) begin : g_unit
    assign elig[g]                    = dest[g] & started[g];
    assign key_flat[g*KEY_W +: KEY_W] = prio_key(prio_flat[g*PRIO_W +: PRIO_W]);
  end
endmodule

// File: rtl/lp_scan_ctrl.sv
module lp_scan_ctrl #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          launch,
  output logic          active,
  output logic [IW-1:0] step,
  output logic          last
);
  assign launch = req & ~active;
  assign last   = active && (step == IW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
    end else if (launch) begin
      active <= 1'b1;
      step   <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      step   <= step + 1'b1;
    end
  end
endmodule

// File: rtl/lp_best_track.sv
module lp_best_track
  import lp_arb_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             visit,
  input  logic [IW-1:0]    cand_idx,
  input  logic             cand_ok,
  input  logic [KEY_W-1:0] cand_key,
  output logic             nxt_hit,
  output logic [IW-1:0]    nxt_idx
);
  logic [KEY_W-1:0] best_key;
  logic [IW-1:0]    best_idx;
  logic             best_hit;
  logic             take;

  // Strictly lower replaces: the first-visited unit keeps a tie.
  assign take    = visit & cand_ok & (cand_key < best_key);
  assign nxt_hit = best_hit | take;
  assign nxt_idx = take ? cand_idx : best_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_key <= KEY_NONE;
      best_idx <= '0;
      best_hit <= 1'b0;
    end else if (clear) begin
      best_key <= KEY_NONE;
      best_idx <= '0;
      best_hit <= 1'b0;
    end else if (take) begin
      best_key <= cand_key;
      best_idx <= cand_idx;
      best_hit <= 1'b1;
    end
  end
endmodule

// File: rtl/lowpri_arbiter.sv
module lowpri_arbiter
  import lp_arb_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [N-1:0]       dest_i,
  input  logic [N-1:0]       started_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic               done_o,
  output logic               found_o,
  output logic [N-1:0]       win_mask_o,
  output logic [IW-1:0]      win_idx_o
);
  logic [N-1:0]       elig_now;
  logic [N*KEY_W-1:0] key_now;
  logic [N-1:0]       elig_q;
  logic [KEY_W-1:0]   key_q [N];
  logic               launch, active, last;
  logic [IW-1:0]      step;
  logic [IW-1:0]      rot_ptr;
  logic [IW-1:0]      cand_idx;
  logic               nxt_hit;
  logic [IW-1:0]      nxt_idx;
  logic [N-1:0]       mask_nxt;

  lp_eligible #(.N(N)) u_elig (
    .dest      (dest_i),
    .started   (started_i),
    .prio_flat (prio_i),
    .elig      (elig_now),
    .key_flat  (key_now)
  );

  lp_scan_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_i),
    .launch (launch),
    .active (active),
    .step   (step),
    .last   (last)
  );

  // Snapshot of eligibility and keys taken at the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_q <= '0;
    else if (launch) elig_q <= elig_now;
  end

  for (genvar g = 0; g < N; g++) begin : g_keyq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[g] <= KEY_NONE;
      else if (launch) key_q[g] <= key_now[g*KEY_W +: KEY_W];
    end
  end

  assign cand_idx = IW'(ring_add(32'(rot_ptr), 32'(step), 32'(N)));

  lp_best_track #(.N(N)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .visit    (active),
    .cand_idx (cand_idx),
    .cand_ok  (elig_q[cand_idx]),
    .cand_key (key_q[cand_idx]),
    .nxt_hit  (nxt_hit),
    .nxt_idx  (nxt_idx)
  );

  always_comb begin
    mask_nxt = '0;
    mask_nxt[nxt_idx] = nxt_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      found_o    <= 1'b0;
      win_mask_o <= '0;
      win_idx_o  <= '0;
      rot_ptr    <= '0;
    end else if (last) begin
      done_o     <= 1'b1;
      found_o    <= nxt_hit;
      win_mask_o <= mask_nxt;
      win_idx_o  <= nxt_idx;
      if (nxt_hit) rot_ptr <= IW'(ring_add(32'(nxt_idx), 32'd1, 32'(N)));
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lp_arb_chk.sv
module lp_arb_chk #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          last,
  input logic          done_o,
  input logic          found_o,
  input logic [N-1:0]  win_mask_o,
  input logic [IW-1:0] win_idx_o,
  input logic [IW-1:0] rot_ptr,
  input logic [N-1:0]  elig_q
);
  logic [IW-1:0] ptr_exp;
  assign ptr_exp = (win_idx_o == IW'(N - 1)) ? '0 : win_idx_o + 1'b1;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done_o);
  // R6
  mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(win_mask_o) == (found_o ? 1 : 0)));
  // R6
  mask_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> win_mask_o[win_idx_o]);
  // R1
  winner_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> elig_q[win_idx_o]);
  // R5
  ptr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (rot_ptr == ptr_exp));
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !found_o) |-> $stable(rot_ptr));
endmodule

bind lowpri_arbiter lp_arb_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .last       (last),
  .done_o     (done_o),
  .found_o    (found_o),
  .win_mask_o (win_mask_o),
  .win_idx_o  (win_idx_o),
  .rot_ptr    (rot_ptr),
  .elig_q     (elig_q)
);

// File: tb/lowpri_arbiter_tb.sv
module lowpri_arbiter_tb;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  typedef struct {
    logic          found;
    logic [IW-1:0] idx;
    logic [N-1:0]  mask;
    int            due;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [N-1:0]   dest_i = '0;
  logic [N-1:0]   started_i = '0;
  logic [N*8-1:0] prio_i = '0;
  logic done_o, found_o;
  logic [N-1:0]  win_mask_o;
  logic [IW-1:0] win_idx_o;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   m_ptr = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lowpri_arbiter #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .dest_i(dest_i),
    .started_i(started_i), .prio_i(prio_i), .done_o(done_o),
    .found_o(found_o), .win_mask_o(win_mask_o), .win_idx_o(win_idx_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Reference walk: eligibility, nibble keys, ring order, strict-lower replace.
  task automatic predict(input logic [N-1:0] d, input logic [N-1:0] s,
                         input logic [N*8-1:0] p, input string tag);
    exp_t e;
    int best = 16;
    int bidx = 0;
    for (int i = 0; i < N; i++) begin
      int u = (m_ptr + i) % N;
      int k = int'(p[u*8+4 +: 4]);
      if (d[u] && s[u] && k < best) begin
        best = k;
        bidx = u;
      end
    end
    e.found = (best < 16);
    e.idx   = IW'(bidx);
    e.mask  = e.found ? (N'(1) << bidx) : '0;
    e.due   = cyc + 1 + N;
    e.tag   = tag;
    if (e.found) m_ptr = (bidx + 1) % N;
    q.push_back(e);
  endtask

  // Driver: one request, optional disturbance while the walk runs (R9).
  task automatic run(input logic [N-1:0] d, input logic [N-1:0] s,
                     input logic [N*8-1:0] p, input string tag, input bit disturb);
    @(negedge clk);
    dest_i = d; started_i = s; prio_i = p; req_i = 1'b1;
    predict(d, s, p, tag);
    @(negedge clk);
    req_i = 1'b0;
    if (disturb) begin
      for (int k = 0; k < N - 2; k++) begin
        req_i = 1'b1;
        dest_i = N'($urandom); started_i = N'($urandom);
        prio_i = {$urandom, $urandom};
        @(negedge clk);
      end
      req_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pop and compare on each done strobe.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 done with nothing queued", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.due, {e.tag, " R8 latency"}, cyc, e.due);
        check(found_o == e.found, {e.tag, " found"}, int'(found_o), int'(e.found));
        check(win_mask_o == e.mask, {e.tag, " R6 mask"}, int'(win_mask_o), int'(e.mask));
        if (e.found)
          check(win_idx_o == e.idx, {e.tag, " R6 index"}, int'(win_idx_o), int'(e.idx));
      end
    end
  end

  function automatic logic [N*8-1:0] fill(input logic [7:0] v);
    logic [N*8-1:0] r;
    for (int u = 0; u < N; u++) r[u*8 +: 8] = v;
    return r;
  endfunction

  initial begin
    logic [N*8-1:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R8 reset done", int'(done_o), 0);
    check(found_o == 1'b0 && win_mask_o == '0 && win_idx_o == '0,
          "R6 reset outputs", int'(win_mask_o), 0);

    // R5: pointer starts at 0, so a full tie goes to unit 0, then unit 1.
    run('1, '1, fill(8'h50), "R5 tie after reset", 1'b0);
    run('1, '1, fill(8'h50), "R4 tie rotates", 1'b0);

    // R2: 0x2F and 0x20 share nibble 2; unit 3 is visited first.
    p = fill(8'h90); p[3*8 +: 8] = 8'h2F; p[5*8 +: 8] = 8'h20;
    run('1, '1, p, "R2 low nibble ignored", 1'b0);

    // R3: smallest nibble wins.
    p = fill(8'h80); p[0 +: 8] = 8'h10; p[6*8 +: 8] = 8'h30;
    run('1, '1, p, "R3 lowest wins", 1'b0);

    // R1: lower units not started / not in destination are skipped.
    p = fill(8'hC0); p[2*8 +: 8] = 8'h00; p[4*8 +: 8] = 8'h00; p[7*8 +: 8] = 8'h40;
    run(8'b1110_1111, 8'b1111_1011, p, "R1 eligibility", 1'b0);

    // R7: nothing eligible, pointer held (next tie lands on same unit).
    run('0, '1, fill(8'h10), "R7 empty dest", 1'b0);
    run('1, '0, fill(8'h10), "R7 none started", 1'b0);
    run('1, '1, fill(8'h70), "R7 pointer held", 1'b0);

    // R9: requests and input changes during the walk are ignored.
    run('1, '1, fill(8'h70), "R9 mid-walk disturbance", 1'b1);
    p = fill(8'hF0); p[6*8 +: 8] = 8'h05;
    run(8'h41, 8'h41, p, "R9 disturbance with winner", 1'b1);

    for (int i = 0; i < 24; i++)
      run(N'($urandom), N'($urandom | $urandom), {$urandom, $urandom},
          "R3 random", bit'(i % 3 == 0));

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R8 results outstanding", q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule